// File: doc/BRIEF.md
# Dual-Core Redundant Write Commit Buffer

Two cores run the same thread side by side, each behind its own write-through L1 cache. Every store leaves an L1 as a line address with data. This block sits between those caches and the shared L2. Each core pushes its stores into a section of its own. A store goes to L2 only after both cores have produced it, and only one copy is written. A core that runs ahead waits for the other: its stores stay queued until the matching address appears at the head of the partner section.

Each queued entry is stored with a SECDED check code. A single flipped bit is repaired when the entry is read. A double flip raises an uncorrectable flag. An error handler outside this block can freeze all traffic. It can also order a recovery copy, in which the contents and pointers of the section it names as correct overwrite the other section.

A small controller has three states. `ST_RUN` passes traffic. `ST_HOLD` is entered from `ST_RUN` when freeze is sampled high, and returns to `ST_RUN` when freeze is sampled low. `ST_COPY` is entered from `ST_RUN` or `ST_HOLD` when a clone request is sampled; it takes priority over freeze. The copy is applied at the edge that leaves `ST_COPY`. From there the controller goes to `ST_HOLD` if freeze is high, and to `ST_RUN` otherwise.

Top module: `dual_commit_buf`

## Requirements
- R1: Core A stores go only into section 0 and core B stores go only into section 1. A store is taken on a clock edge where that core's valid and ready are both high.
- R2: `l2_valid` is high only when both sections hold an entry and their oldest entries carry the same line address. While the two oldest addresses differ, nothing is offered to L2.
- R3: When `l2_valid` and `l2_ready` are both high at an edge, the oldest entry leaves both sections. Each matched pair therefore gives exactly one L2 write.
- R4: Entries of a core that is ahead stay queued in arrival order until the other core supplies the matching address. They are then committed oldest first.
- R5: `l2_addr` and `l2_data` are taken from the section 0 entry. The data that core B pushed is never sent.
- R6: Each section holds 10 entries. When a section is full, only that core's ready goes low, and the other core keeps its ready.
- R7: Every entry is stored as a SECDED codeword: 16 payload bits, 5 Hamming bits and one overall parity bit, 22 bits in all. Flipping any single bit of a stored word gives back the original payload with no flag. Flipping any two bits sets the uncorrectable flag. The top drives `unc_err` when an occupied head is uncorrectable, and blocks commit while it is set.
- R8: While `freeze` is high, `l2_valid`, `a_ready` and `b_ready` are low in the same cycle. Queued entries are kept. Traffic resumes one cycle after `freeze` is sampled low.
- R9: A `clone_req` sampled high gives one `ST_COPY` cycle, in which `l2_valid`, `a_ready` and `b_ready` are low. At the end of that cycle, the section named by `clone_src` (0 = section 0 is correct, 1 = section 1 is correct) is copied, contents and pointers, over the other section.
- R10: Once `l2_valid` is high without `l2_ready`, the same address and data stay on the port until accepted, unless freeze or a recovery copy intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Core A offers a store |
| a_addr | input | 8 | Core A line address |
| a_data | input | 8 | Core A store data |
| a_ready | output | 1 | Section 0 can accept a store |
| b_valid | input | 1 | Core B offers a store |
| b_addr | input | 8 | Core B line address |
| b_data | input | 8 | Core B store data |
| b_ready | output | 1 | Section 1 can accept a store |
| l2_valid | output | 1 | A matched store is offered to L2 |
| l2_ready | input | 1 | L2 accepts the offered store |
| l2_addr | output | 8 | Committed line address |
| l2_data | output | 8 | Committed data (from section 0) |
| freeze | input | 1 | Block pushes and commit |
| clone_req | input | 1 | Request a recovery copy |
| clone_src | input | 1 | Section holding correct state |
| unc_err | output | 1 | An occupied head has an uncorrectable error |

## Verification
The hardest case to reach is a corrupted stored word. No port can flip a bit inside a section, so the bench drives the same encoder and decoder pair on its own. It flips every single bit of several codewords and a few bit pairs. The recovery copy is the other hard case. It is reached by loading the two sections with different address streams, so that commit stalls on the mismatch, and then requesting a copy in each direction. The bench then checks that the commits that follow use the surviving section's addresses and data.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_COPY = 2'd2
    } wcb_state_t;

    // Hamming bits needed to cover k payload bits
    function automatic int pbits(input int k);
        int p;
        p = 1;
        for (int i = 1; i < 16; i++) begin
            if ((1 << p) < (k + p + 1)) p = p + 1;
        end
        return p;
    endfunction

endpackage

// File: rtl/wcb_secded_enc.sv
module wcb_secded_enc #(
    parameter int KW = 16
) (
    input  logic [KW-1:0]                      d,
    output logic [KW+wcb_pkg::pbits(KW):0]     c
);
    localparam int P = wcb_pkg::pbits(KW);
    localparam int N = KW + P;

    logic [N-1:0] pos;
    logic [P-1:0] syn;

    always_comb begin
        int k;
        k   = 0;
        pos = '0;
        syn = '0;
        for (int j = 1; j <= N; j++) begin
            if ((j & (j - 1)) != 0) begin
                pos[j-1] = d[k];
                k = k + 1;
            end
        end
        for (int j = 1; j <= N; j++) begin
            if (pos[j-1]) syn = syn ^ P'(j);
        end
        for (int i = 0; i < P; i++) begin
            pos[(1 << i) - 1] = syn[i];
        end
        c = {^pos, pos};
    end
endmodule

// File: rtl/wcb_secded_dec.sv
module wcb_secded_dec #(
    parameter int KW = 16
) (
    input  logic [KW+wcb_pkg::pbits(KW):0]     c,
    output logic [KW-1:0]                      d,
    output logic                               dbl
);
    localparam int P = wcb_pkg::pbits(KW);
    localparam int N = KW + P;

    logic [N-1:0] fixed;
    logic [P-1:0] syn;
    logic         par;

    always_comb begin
        int k;
        syn = '0;
        for (int j = 1; j <= N; j++) begin
            if (c[j-1]) syn = syn ^ P'(j);
        end
        par   = ^c;
        fixed = c[N-1:0];
        dbl   = 1'b0;
        if (par) begin
            if (syn != '0) begin
                if (int'(syn) <= N) fixed[int'(syn) - 1] = ~c[int'(syn) - 1];
                else                dbl = 1'b1;
            end
        end else if (syn != '0) begin
            dbl = 1'b1;
        end
        k = 0;
        d = '0;
        for (int j = 1; j <= N; j++) begin
            if ((j & (j - 1)) != 0) begin
                d[k] = fixed[j-1];
                k = k + 1;
            end
        end
    end
endmodule

// File: rtl/wcb_section.sv
module wcb_section #(
    parameter int CW    = 22,
    parameter int DEPTH = 10,
    localparam int PW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [CW-1:0]   push_word,
    input  logic            pop,
    input  logic            load,
    input  logic [CW-1:0]   ld_mem [DEPTH],
    input  logic [PW-1:0]   ld_wp,
    input  logic [PW-1:0]   ld_rp,
    input  logic [CNTW-1:0] ld_cnt,
    output logic [CW-1:0]   mem_o [DEPTH],
    output logic [PW-1:0]   wp_o,
    output logic [PW-1:0]   rp_o,
    output logic [CNTW-1:0] cnt_o,
    output logic [CW-1:0]   head_o
);
    logic [CW-1:0]   mem_q [DEPTH];
    logic [PW-1:0]   wp_q, rp_q;
    logic [CNTW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] v);
        return (v == PW'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (load) begin
            wp_q  <= ld_wp;
            rp_q  <= ld_rp;
            cnt_q <= ld_cnt;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ld_mem[i];
        end else begin
            if (push) begin
                mem_q[wp_q] <= push_word;
                wp_q        <= bump(wp_q);
            end
            if (pop) rp_q <= bump(rp_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign mem_o  = mem_q;
    assign wp_o   = wp_q;
    assign rp_o   = rp_q;
    assign cnt_o  = cnt_q;
    assign head_o = mem_q[rp_q];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(DEPTH)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt_q != '0); // R3
endmodule

// File: rtl/dual_commit_buf.sv
module dual_commit_buf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    output logic              a_ready,
    input  logic              b_valid,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    output logic              b_ready,
    output logic              l2_valid,
    input  logic              l2_ready,
    output logic [ADDR_W-1:0] l2_addr,
    output logic [DATA_W-1:0] l2_data,
    input  logic              freeze,
    input  logic              clone_req,
    input  logic              clone_src,
    output logic              unc_err
);
    import wcb_pkg::*;

    localparam int KW   = ADDR_W + DATA_W;
    localparam int P    = pbits(KW);
    localparam int CW   = KW + P + 1;
    localparam int PW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    wcb_state_t state_q, state_d;
    logic       src_q;

    logic [1:0]      in_valid, ready, push, load, nonempty, full, dbl;
    logic [KW-1:0]   in_pl   [2];
    logic [KW-1:0]   dec_pl  [2];
    logic [CW-1:0]   enc_w   [2];
    logic [CW-1:0]   head_w  [2];
    logic [CW-1:0]   mem_s   [2][DEPTH];
    logic [PW-1:0]   wp_s    [2];
    logic [PW-1:0]   rp_s    [2];
    logic [CNTW-1:0] cnt_s   [2];
    logic            accept, match, pop;

    assign in_valid = {b_valid, a_valid};
    assign in_pl[0] = {a_addr, a_data};
    assign in_pl[1] = {b_addr, b_data};

    for (genvar g = 0; g < 2; g++) begin : g_sec
        wcb_secded_enc #(.KW(KW)) u_enc (.d(in_pl[g]), .c(enc_w[g]));

        wcb_section #(.CW(CW), .DEPTH(DEPTH)) u_sec (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[g]),
            .push_word (enc_w[g]),
            .pop       (pop),
            .load      (load[g]),
            .ld_mem    (mem_s[1-g]),
            .ld_wp     (wp_s[1-g]),
            .ld_rp     (rp_s[1-g]),
            .ld_cnt    (cnt_s[1-g]),
            .mem_o     (mem_s[g]),
            .wp_o      (wp_s[g]),
            .rp_o      (rp_s[g]),
            .cnt_o     (cnt_s[g]),
            .head_o    (head_w[g])
        );

        wcb_secded_dec #(.KW(KW)) u_dec (.c(head_w[g]), .d(dec_pl[g]), .dbl(dbl[g]));

        assign nonempty[g] = cnt_s[g] != '0;
        assign full[g]     = cnt_s[g] == CNTW'(DEPTH);
        assign ready[g]    = accept && !full[g];
        assign push[g]     = in_valid[g] && ready[g];
        assign load[g]     = (state_q == ST_COPY) && (src_q != g[0]);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clone_req && state_q != ST_COPY) src_q <= clone_src;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (clone_req) state_d = ST_COPY;
                     else if (freeze) state_d = ST_HOLD;
            ST_HOLD: if (clone_req) state_d = ST_COPY;
                     else if (!freeze) state_d = ST_RUN;
            ST_COPY: state_d = freeze ? ST_HOLD : ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        accept   = (state_q == ST_RUN) && !freeze;
        unc_err  = (nonempty[0] && dbl[0]) || (nonempty[1] && dbl[1]);
        match    = nonempty[0] && nonempty[1] && !unc_err &&
                   (dec_pl[0][KW-1:DATA_W] == dec_pl[1][KW-1:DATA_W]);
        l2_valid = accept && match;
        pop      = l2_valid && l2_ready;
        l2_addr  = dec_pl[0][KW-1:DATA_W];
        l2_data  = dec_pl[0][DATA_W-1:0];
        a_ready  = ready[0];
        b_ready  = ready[1];
    end

    AST_BOTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        l2_valid |-> (cnt_s[0] != '0) && (cnt_s[1] != '0)); // R2
    AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_valid && $past(l2_valid && !l2_ready)) |-> $stable(l2_addr) && $stable(l2_data)); // R10
    AST_COPY_B_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_COPY && !src_q) |-> cnt_s[1] == $past(cnt_s[0])); // R9
    AST_COPY_A_FROM_B: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_COPY && src_q) |-> cnt_s[0] == $past(cnt_s[1])); // R9
    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !push[0] && !push[1]); // R8
endmodule

// File: tb/dual_commit_buf_tb.sv
module dual_commit_buf_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid = 0, b_valid = 0, l2_ready = 0, freeze = 0, clone_req = 0, clone_src = 0;
    logic [7:0] a_addr = 0, a_data = 0, b_addr = 0, b_data = 0;
    logic a_ready, b_ready, l2_valid, unc_err;
    logic [7:0] l2_addr, l2_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_commit_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_addr(a_addr), .a_data(a_data), .a_ready(a_ready),
        .b_valid(b_valid), .b_addr(b_addr), .b_data(b_data), .b_ready(b_ready),
        .l2_valid(l2_valid), .l2_ready(l2_ready), .l2_addr(l2_addr), .l2_data(l2_data),
        .freeze(freeze), .clone_req(clone_req), .clone_src(clone_src), .unc_err(unc_err)
    );

    // standalone codec for R7
    logic [15:0] cd_in;
    logic [21:0] cd_word, cd_bad;
    logic [15:0] cd_out;
    logic        cd_dbl;
    wcb_secded_enc #(.KW(16)) u_cenc (.d(cd_in), .c(cd_word));
    wcb_secded_dec #(.KW(16)) u_cdec (.c(cd_bad), .d(cd_out), .dbl(cd_dbl));

    // addr, core A data, core B data
    localparam logic [23:0] VEC [6] = '{
        24'h10_3C_C3, 24'h11_00_FF, 24'hFF_A5_5A,
        24'h00_7E_81, 24'h80_01_02, 24'h2B_FF_00
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_a(input logic [7:0] ad, input logic [7:0] dt);
        a_valid = 1; a_addr = ad; a_data = dt;
        step();
        a_valid = 0;
    endtask

    task automatic push_b(input logic [7:0] ad, input logic [7:0] dt);
        b_valid = 1; b_addr = ad; b_data = dt;
        step();
        b_valid = 0;
    endtask

    task automatic take(input logic [7:0] ad, input logic [7:0] dt, input string req);
        chk(l2_valid === 1'b1, req, {31'd0, l2_valid}, 1);
        chk(l2_addr === ad, req, {24'd0, l2_addr}, {24'd0, ad});
        chk(l2_data === dt, req, {24'd0, l2_data}, {24'd0, dt});
        l2_ready = 1;
        step();
        l2_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        rst_n = 1;
        step();
        // reset state
        chk(l2_valid === 0, "reset", {31'd0, l2_valid}, 0);
        chk(a_ready === 1 && b_ready === 1, "reset R1", {30'd0, a_ready, b_ready}, 3);
        chk(unc_err === 0, "reset R7", {31'd0, unc_err}, 0);

        // table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < 6; v++) begin
            push_a(VEC[v][23:16], VEC[v][15:8]);
            chk(l2_valid === 0, "R4 faster core waits", {31'd0, l2_valid}, 0);
            push_b(VEC[v][23:16], VEC[v][7:0]);
            take(VEC[v][23:16], VEC[v][15:8], "R2 R5 commit");
            chk(l2_valid === 0, "R3 single copy", {31'd0, l2_valid}, 0);
        end

        // full section: R6, ordering R4, hold R10
        for (int i = 0; i < 10; i++) push_a(8'(i + 8'h40), 8'(i + 8'h70));
        chk(a_ready === 0, "R6 full A", {31'd0, a_ready}, 0);
        chk(b_ready === 1, "R6 B ready", {31'd0, b_ready}, 1);
        chk(l2_valid === 0, "R2 B empty", {31'd0, l2_valid}, 0);
        for (int i = 0; i < 10; i++) push_b(8'(i + 8'h40), 8'hEE);
        chk(b_ready === 0, "R6 full B", {31'd0, b_ready}, 0);
        repeat (3) step();
        chk(l2_valid === 1 && l2_addr === 8'h40, "R10 hold", {24'd0, l2_addr}, 32'h40);
        for (int i = 0; i < 10; i++) take(8'(i + 8'h40), 8'(i + 8'h70), "R4 order");
        chk(l2_valid === 0, "R3 drained", {31'd0, l2_valid}, 0);
        chk(a_ready === 1, "R6 ready back", {31'd0, a_ready}, 1);

        // freeze: R8
        push_a(8'h55, 8'h12);
        push_b(8'h55, 8'h34);
        freeze = 1; #1;
        chk(l2_valid === 0 && a_ready === 0 && b_ready === 0, "R8 frozen",
            {29'd0, l2_valid, a_ready, b_ready}, 0);
        step();
        chk(l2_valid === 0, "R8 still frozen", {31'd0, l2_valid}, 0);
        freeze = 0; #1;
        chk(l2_valid === 0, "R8 one more cycle", {31'd0, l2_valid}, 0);
        step();
        take(8'h55, 8'h12, "R8 resumed");

        // clone A over B: R9, mismatch R2
        push_a(8'h31, 8'hA1); push_a(8'h32, 8'hA2); push_a(8'h33, 8'hA3);
        push_b(8'h90, 8'hB0); push_b(8'h91, 8'hB1);
        chk(l2_valid === 0, "R2 mismatch waits", {31'd0, l2_valid}, 0);
        clone_src = 0; clone_req = 1;
        step();
        clone_req = 0;
        chk(l2_valid === 0 && a_ready === 0 && b_ready === 0, "R9 copy cycle",
            {29'd0, l2_valid, a_ready, b_ready}, 0);
        step();
        take(8'h31, 8'hA1, "R9 A to B");
        take(8'h32, 8'hA2, "R9 A to B");
        take(8'h33, 8'hA3, "R9 A to B");
        chk(l2_valid === 0, "R9 both emptied", {31'd0, l2_valid}, 0);

        // clone B over A
        push_a(8'h50, 8'h55);
        push_b(8'h60, 8'h66); push_b(8'h61, 8'h67);
        clone_src = 1; clone_req = 1;
        step();
        clone_req = 0;
        step();
        take(8'h60, 8'h66, "R9 B to A");
        take(8'h61, 8'h67, "R9 B to A");
        chk(l2_valid === 0, "R9 B to A empty", {31'd0, l2_valid}, 0);

        // codec: R7
        for (int p = 0; p < 4; p++) begin
            bit ok;
            cd_in = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : (p == 2) ? 16'hA53C : 16'h1234;
            #1;
            cd_bad = cd_word; #1;
            chk(cd_out === cd_in && cd_dbl === 0, "R7 clean", {16'd0, cd_out}, {16'd0, cd_in});
            ok = 1;
            for (int b = 0; b < 22; b++) begin
                cd_bad = cd_word ^ (22'd1 << b); #1;
                if (cd_out !== cd_in || cd_dbl !== 0) ok = 0;
            end
            chk(ok, "R7 single flips", {31'd0, ok}, 1);
            cd_bad = cd_word ^ 22'h000021; #1;
            chk(cd_dbl === 1, "R7 double flag", {31'd0, cd_dbl}, 1);
            cd_bad = cd_word ^ 22'h300000; #1;
            chk(cd_dbl === 1, "R7 double flag hi", {31'd0, cd_dbl}, 1);
        end
        chk(unc_err === 0, "R7 no false flag", {31'd0, unc_err}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule